// File: doc/BRIEF.md
# Token-Bucket Port Rate Limiter

This block paces the packets leaving one output port. Each packet has a cost made of two parts: a fixed charge per packet, and a charge for every 8-byte word it carries. The block keeps a running debt. Every granted packet adds its cost to the debt, and the debt drains by a fixed 16 tokens on each clock. A new packet is granted only while the debt is below a programmed burst limit. Setting the per-word charge to zero gives a packets-per-second limiter. A non-zero per-word charge gives a bit-rate limiter. In that case the fixed charge should also cover the 24 bytes of line overhead that the word count does not include: 12 bytes of inter-frame gap, 8 of preamble and 4 of CRC.

The two granularities differ. The fixed charge and the limit are programmed in units of 256 tokens, while the per-word charge is in single tokens. Configuration writes carry a port identifier, and the block accepts only writes that carry its own identifier. A requester raises `req_valid` with the packet's word count and holds it until `grant` pulses.

Top module: `port_rate_shaper`

## Requirements
- R1: After reset the debt is zero, `grant` is low and all three settings are zero; with the limit at zero no request is ever granted.
- R2: `grant` is a single-cycle pulse, asserted the cycle after an edge at which `req_valid` was high and the debt was strictly below limit×256. No request is evaluated at an edge where `grant` is already high, so a held request sees at least two cycles between grants.
- R3: A grant adds pkt_cost×256 + word_cost×`req_words` to the debt.
- R4: Every clock the debt drops by 16, saturating at zero, so an idle port regains the full budget and its next request is granted at once.
- R5: With word_cost zero, grant timing does not depend on `req_words`.
- R6: A configuration write whose `cfg_port` differs from parameter `MY_PORT` changes nothing.
- R7: `cfg_sel` picks the field written from `cfg_data` low bits: 0 = packet cost, 1 = word cost, 2 = limit; code 3 writes nothing.
- R8: A granted packet may push the debt past the limit by up to its full cost. The debt register never wraps, including at the largest settings and word count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | PORT_W | Port identifier carried by the write |
| cfg_sel | input | 2 | Field select (0 packet cost, 1 word cost, 2 limit, 3 none) |
| cfg_data | input | CFG_W | Field value, low bits used |
| req_valid | input | 1 | Packet waiting to be sent |
| req_words | input | WCNT_W | Length of the waiting packet in 8-byte words |
| grant | output | 1 | One-cycle pulse: packet accepted and charged |

## Verification
The main stimulus is a sweep over limits of 1 to 3, packet costs of 0 to 2, word costs of 0 and 3, and word counts of 0, 5 and the maximum of 63. Each run starts from a drained bucket and holds a request for four grants. The gaps between grants are computed arithmetically from the charge and the 16-token refill. Runs with a packet cost above the limit separate a correct overdraft from a refusal. Runs where only the word count changes, with a word cost of zero, show whether length leaks into packet-rate mode. One run at the largest settings exposes a debt register that is too narrow. Separate probes cover zero limit after reset, foreign port identifiers and the unused select code, each by watching whether a held request is granted.

// File: rtl/rls_pkg.sv
`timescale 1ns/1ps
package rls_pkg;
  typedef enum logic [1:0] {
    CFG_PKT_COST  = 2'd0,
    CFG_WORD_COST = 2'd1,
    CFG_LIMIT     = 2'd2,
    CFG_SPARE     = 2'd3
  } cfg_field_e;

  localparam int unsigned FIELD_CNT = 3;
endpackage

// File: rtl/rls_rst_sync.sv
`timescale 1ns/1ps
module rls_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= 1'b0;
        else         stage_q <= 1'b1;
      end
      assign rst_sync_n = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rls_cfg_regs.sv
`timescale 1ns/1ps
module rls_cfg_regs
  import rls_pkg::*;
#(
  parameter int PORT_W  = 4,
  parameter int MY_PORT = 5,
  parameter int CFG_W   = 8,
  parameter int PKT_W   = 8,
  parameter int WORD_W  = 8,
  parameter int LIM_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic [PKT_W-1:0]  pkt_cost,
  output logic [WORD_W-1:0] word_cost,
  output logic [LIM_W-1:0]  limit
);
  localparam logic [PORT_W-1:0] OWN_ID = PORT_W'(MY_PORT);

  logic                 id_hit;
  logic [FIELD_CNT-1:0] fld_en;
  logic [PKT_W-1:0]     pkt_d;
  logic [WORD_W-1:0]    word_d;
  logic [LIM_W-1:0]     lim_d;

  // decode: which field (if any) this write targets
  always_comb begin
    id_hit = cfg_we && (cfg_port == OWN_ID);
    fld_en = '0;
    if (id_hit) begin
      case (cfg_field_e'(cfg_sel))
        CFG_PKT_COST:  fld_en[0] = 1'b1;
        CFG_WORD_COST: fld_en[1] = 1'b1;
        CFG_LIMIT:     fld_en[2] = 1'b1;
        default:       fld_en    = '0;
      endcase
    end
  end

  // next-state values
  always_comb begin
    pkt_d  = cfg_data[PKT_W-1:0];
    word_d = cfg_data[WORD_W-1:0];
    lim_d  = cfg_data[LIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_cost  <= '0;
      word_cost <= '0;
      limit     <= '0;
    end else begin
      if (fld_en[0]) pkt_cost  <= pkt_d;
      if (fld_en[1]) word_cost <= word_d;
      if (fld_en[2]) limit     <= lim_d;
    end
  end
endmodule

// File: rtl/rls_charge.sv
`timescale 1ns/1ps
module rls_charge #(
  parameter int PKT_W  = 8,
  parameter int WORD_W = 8,
  parameter int WCNT_W = 6,
  parameter int SHIFT  = 8,
  parameter int COST_W = 18
) (
  input  logic [PKT_W-1:0]  pkt_cost,
  input  logic [WORD_W-1:0] word_cost,
  input  logic [WCNT_W-1:0] words,
  output logic [COST_W-1:0] charge
);
  logic [COST_W-1:0] fixed_part;
  logic [COST_W-1:0] len_part;

  always_comb begin
    fixed_part = COST_W'(pkt_cost) << SHIFT;
    len_part   = COST_W'(word_cost) * COST_W'(words);
    charge     = fixed_part + len_part;
  end
endmodule

// File: rtl/rls_bucket.sv
`timescale 1ns/1ps
module rls_bucket #(
  parameter int DEBT_W = 18,
  parameter int LIM_W  = 8,
  parameter int SHIFT  = 8,
  parameter int REFILL = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              charge_en,
  input  logic [DEBT_W-1:0] charge,
  input  logic [LIM_W-1:0]  limit,
  output logic [DEBT_W-1:0] debt,
  output logic              below_limit
);
  localparam logic [DEBT_W-1:0] DRAIN = DEBT_W'(REFILL);

  logic [DEBT_W-1:0] drained;
  logic [DEBT_W-1:0] debt_d;
  logic [DEBT_W-1:0] threshold;
  logic              debt_en;

  always_comb begin
    drained     = (debt > DRAIN) ? (debt - DRAIN) : '0;
    debt_d      = drained + (charge_en ? charge : '0);
    debt_en     = charge_en || (debt != '0);
    threshold   = DEBT_W'(limit) << SHIFT;
    below_limit = (debt < threshold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       debt <= '0;
    else if (debt_en) debt <= debt_d;
  end
endmodule

// File: rtl/port_rate_shaper.sv
`timescale 1ns/1ps
module port_rate_shaper #(
  parameter int PORT_W     = 4,
  parameter int MY_PORT    = 5,
  parameter int CFG_W      = 8,
  parameter int PKT_W      = 8,
  parameter int WORD_W     = 8,
  parameter int LIM_W      = 8,
  parameter int WCNT_W     = 6,
  parameter int TOK_SHIFT  = 8,
  parameter int REFILL     = 16,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              req_valid,
  input  logic [WCNT_W-1:0] req_words,
  output logic              grant
);
  // worst debt: just under the limit, plus the largest single charge
  localparam longint unsigned LIM_MAX  = ((longint'(1) << LIM_W) - 1) << TOK_SHIFT;
  localparam longint unsigned PKT_MAX  = ((longint'(1) << PKT_W) - 1) << TOK_SHIFT;
  localparam longint unsigned LEN_MAX  = ((longint'(1) << WORD_W) - 1) * ((longint'(1) << WCNT_W) - 1);
  localparam longint unsigned DEBT_MAX = LIM_MAX + PKT_MAX + LEN_MAX;
  localparam int DEBT_W = $clog2(DEBT_MAX + 1);

  logic              rst_i_n;
  logic [PKT_W-1:0]  pkt_cost;
  logic [WORD_W-1:0] word_cost;
  logic [LIM_W-1:0]  limit;
  logic [DEBT_W-1:0] charge;
  logic [DEBT_W-1:0] debt;
  logic              below_limit;
  logic              accept;
  logic              grant_q;

  rls_rst_sync #(.STAGES(SYNC_STAGE)) rst_i (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_i_n)
  );

  rls_cfg_regs #(
    .PORT_W (PORT_W), .MY_PORT (MY_PORT), .CFG_W (CFG_W),
    .PKT_W  (PKT_W),  .WORD_W  (WORD_W),  .LIM_W (LIM_W)
  ) cfg_i (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cfg_we    (cfg_we),
    .cfg_port  (cfg_port),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .pkt_cost  (pkt_cost),
    .word_cost (word_cost),
    .limit     (limit)
  );

  rls_charge #(
    .PKT_W (PKT_W), .WORD_W (WORD_W), .WCNT_W (WCNT_W),
    .SHIFT (TOK_SHIFT), .COST_W (DEBT_W)
  ) charge_i (
    .pkt_cost  (pkt_cost),
    .word_cost (word_cost),
    .words     (req_words),
    .charge    (charge)
  );

  rls_bucket #(
    .DEBT_W (DEBT_W), .LIM_W (LIM_W), .SHIFT (TOK_SHIFT), .REFILL (REFILL)
  ) bucket_i (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .charge_en   (accept),
    .charge      (charge),
    .limit       (limit),
    .debt        (debt),
    .below_limit (below_limit)
  );

  // acceptance: the grant cycle itself is never evaluated
  always_comb begin
    accept = req_valid && !grant_q && below_limit;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) grant_q <= 1'b0;
    else          grant_q <= accept;
  end

  assign grant = grant_q;
endmodule

// File: rtl/rls_checker.sv
`timescale 1ns/1ps
module rls_checker #(
  parameter int DEBT_W  = 18,
  parameter int LIM_W   = 8,
  parameter int PORT_W  = 4,
  parameter int MY_PORT = 5,
  parameter int REFILL  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grant,
  input logic              req_valid,
  input logic              below_limit,
  input logic [DEBT_W-1:0] debt,
  input logic [LIM_W-1:0]  limit,
  input logic              cfg_we,
  input logic [PORT_W-1:0] cfg_port
);
  localparam logic [PORT_W-1:0] OWN_ID = PORT_W'(MY_PORT);
  localparam logic [DEBT_W-1:0] DRAIN  = DEBT_W'(REFILL);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);

  a_r2_needs_budget: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $past(req_valid && below_limit));

  a_r1_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |=> !grant);

  a_r4_refill_step: assert property (@(posedge clk) disable iff (!rst_n)
    (debt >= DRAIN) |=> (grant || (debt == $past(debt) - DRAIN)));

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ({1'b0, debt} + {1'b0, DRAIN} >= {1'b0, $past(debt)}));

  a_r6_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_port != OWN_ID)) |=> $stable(limit));
endmodule

bind port_rate_shaper rls_checker #(
  .DEBT_W (DEBT_W), .LIM_W (LIM_W), .PORT_W (PORT_W),
  .MY_PORT (MY_PORT), .REFILL (REFILL)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .grant       (grant),
  .req_valid   (req_valid),
  .below_limit (below_limit),
  .debt        (debt),
  .limit       (limit),
  .cfg_we      (cfg_we),
  .cfg_port    (cfg_port)
);

// File: tb/port_rate_shaper_tb_top.sv
`timescale 1ns/1ps
module port_rate_shaper_tb_top;
  localparam int PORT_W = 4, MY_PORT = 5, CFG_W = 8, WCNT_W = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [PORT_W-1:0] cfg_port;
  logic [1:0]        cfg_sel;
  logic [CFG_W-1:0]  cfg_data;
  logic              req_valid;
  logic [WCNT_W-1:0] req_words;
  logic              grant;

  int n_checks = 0;
  int n_fail   = 0;
  int last_d   = 0;

  always #2.5 clk = ~clk;

  port_rate_shaper dut_i (
    .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_port (cfg_port),
    .cfg_sel (cfg_sel), .cfg_data (cfg_data), .req_valid (req_valid),
    .req_words (req_words), .grant (grant)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int port, input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_port = PORT_W'(port); cfg_sel = 2'(sel); cfg_data = CFG_W'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic hold_none(input int cycles, input string tag);
    int seen = 0;
    req_valid = 1'b1;
    repeat (cycles) begin
      @(negedge clk);
      if (grant) seen++;
    end
    req_valid = 1'b0;
    check(seen == 0, tag, seen, 0);
  endtask

  function automatic int sat16(input int v);
    return (v > 16) ? v - 16 : 0;
  endfunction

  // one run: returns the sum of the measured gaps between grants
  task automatic run_cfg(input int lim, input int pc, input int wc, input int w, output int gaps);
    int cost, d, dd, k, cnt;
    gaps = 0;
    wr(MY_PORT, 0, pc);
    wr(MY_PORT, 1, wc);
    wr(MY_PORT, 2, lim);
    req_words = WCNT_W'(w);
    repeat (last_d / 16 + 8) @(negedge clk);
    cost = pc * 256 + wc * w;
    req_valid = 1'b1;
    @(negedge clk);
    check(grant == 1'b1, "R4 drained bucket grants at once", int'(grant), 1);
    d = cost;
    for (int g = 0; g < 3; g++) begin
      dd = sat16(d);
      k  = 2;
      while (dd >= lim * 256) begin
        dd = sat16(dd);
        k++;
      end
      cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
        if (cnt == 1) check(grant == 1'b0, "R2 grant is one cycle", int'(grant), 0);
      end while (!grant && cnt < 20000);
      if (d >= lim * 256)
        check(cnt == k, "R8 overdraft gap", cnt, k);
      else
        check(cnt == k, "R3 R4 charge and refill gap", cnt, k);
      gaps += cnt;
      d = sat16(dd) + cost;
    end
    req_valid = 1'b0;
    last_d = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int g, ref_gap;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_port = '0; cfg_sel = '0; cfg_data = '0;
    req_valid = 1'b0; req_words = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(grant == 1'b0, "R1 grant low after reset", int'(grant), 0);
    hold_none(20, "R1 zero limit never grants");

    wr(MY_PORT, 3, 8'hFF);
    hold_none(20, "R7 select code 3 writes nothing");
    wr(MY_PORT + 1, 2, 2);
    hold_none(30, "R6 foreign port write ignored");
    wr(MY_PORT, 2, 2);
    req_valid = 1'b1;
    @(negedge clk);
    check(grant == 1'b1, "R6 own port write accepted", int'(grant), 1);
    req_valid = 1'b0;
    last_d = 0;

    ref_gap = 0;
    for (int lim = 1; lim <= 3; lim++)
      for (int pc = 0; pc <= 2; pc++)
        for (int ci = 0; ci < 2; ci++)
          for (int wi = 0; wi < 3; wi++) begin
            int wc = (ci == 0) ? 0 : 3;
            int w  = (wi == 0) ? 0 : ((wi == 1) ? 5 : 63);
            run_cfg(lim, pc, wc, w, g);
            if (wc == 0) begin
              if (wi == 0) ref_gap = g;
              else check(g == ref_gap, "R5 length ignored in packet mode", g, ref_gap);
            end
          end

    run_cfg(255, 255, 255, 63, g);
    run_cfg(1, 1, 0, 0, g);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule